// File: doc/BRIEF.md
# Cascaded 8-bit Slice ALU

This block is an 8-bit arithmetic/logic unit built from two 4-bit function slices. The slices are chained: the low nibble of each operand goes into the first slice, the high nibble into the second, and the carry ripples from low to high. Two operand registers, A and B, load from a shared 8-bit data bus. A two-bit flag register holds carry and zero. The result goes back onto the bus through an output gate with an active-low enable.

The operation is not picked by a plain opcode. It comes from a 4-bit select, a mode bit and an active-low carry input, as in the classic slice function table. With mode 1 the unit gives sixteen bitwise functions and carry plays no part. With mode 0 it gives sixteen arithmetic functions, and a carry input of 0 adds one to the result.

Top module: `slice_alu8`

## Requirements
- R1: A loads `bus_in` on a rising clock edge when `a_load_n` is 0, and B loads when `b_load_n` is 0. With its load input at 1, a register keeps its value.
- R2: `rst_n` low clears A, B, `cf` and `zf` to 0 at once, without waiting for a clock edge.
- R3: With `mode` = 0, `result` is the low 8 bits of V + k, where k = 1 when `cin_n` = 0 and k = 0 when `cin_n` = 1. V depends on `sel`, with ~B meaning the bitwise inverse of B:
  - 0000: A
  - 0001: A|B
  - 0010: A|~B
  - 0011: 0xFF
  - 0100: A+(A&~B)
  - 0101: (A|B)+(A&~B)
  - 0110: A+~B
  - 0111: (A&~B)+0xFF
  - 1000: A+(A&B)
  - 1001: A+B
  - 1010: (A|~B)+(A&B)
  - 1011: (A&B)+0xFF
  - 1100: A+A
  - 1101: (A|B)+A
  - 1110: (A|~B)+A
  - 1111: A+0xFF
- R4: With `mode` = 1, `result` depends on `sel` only, whatever `cin_n` is:
  - 0000: ~A
  - 0001: ~(A|B)
  - 0010: ~A&B
  - 0011: 0x00
  - 0100: ~(A&B)
  - 0101: ~B
  - 0110: A^B
  - 0111: A&~B
  - 1000: ~A|B
  - 1001: ~(A^B)
  - 1010: B
  - 1011: A&B
  - 1100: 0xFF
  - 1101: A|~B
  - 1110: A|B
  - 1111: A
- R5: The carry out of the low nibble feeds the high nibble. For example, 0x0F + 0x01 gives 0x10.
- R6: On a flag load, `cf` takes bit 8 of the R3 sum (the carry out of the high slice, 1 = carry) in arithmetic mode, and takes 0 in logic mode.
- R7: On a flag load, `zf` takes 1 if the 8-bit result is 0x00, and 0 otherwise.
- R8: The flags load on a rising edge only when `flag_we_n` is 0. With `flag_we_n` at 1 they hold their value. A flag load uses the A and B values from before the edge.
- R9: With `out_en_n` = 0, `bus_oe` = 1 and `bus_out` equals `result`. With `out_en_n` = 1, `bus_oe` = 0 and `bus_out` = 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_in | input | 8 | Data bus value offered to the operand registers |
| a_load_n | input | 1 | Active-low load enable for A |
| b_load_n | input | 1 | Active-low load enable for B |
| flag_we_n | input | 1 | Active-low load enable for the flag register |
| out_en_n | input | 1 | Active-low enable for the output gate |
| sel | input | 4 | Function select |
| mode | input | 1 | 1 = logic mode, 0 = arithmetic mode |
| cin_n | input | 1 | Active-low carry into the low slice |
| result | output | 8 | Combinational function result |
| bus_out | output | 8 | Value driven onto the bus |
| bus_oe | output | 1 | 1 while the block drives the bus |
| cf | output | 1 | Registered carry flag |
| zf | output | 1 | Registered zero flag |

## Verification
The bench runs every select, mode and carry combination over random operands, plus the sums at the edges of the range:
- **Carry across the nibble boundary (0x0F + 0x01).** A broken link between the slices gives 0x00 or 0x1F.
- **Overflow to zero (0x80 + 0x80).** Carry and zero must both be set. A design that drops the carry out or tests the wrong width reports the flags wrongly.
- **Carry in logic mode.** A design that lets `cin_n` reach the logic functions changes their result. One that reports a carry in logic mode leaves `cf` set.
- **Register holds.** Operand loads and flag loads are each withheld while the bus changes. An inverted enable then shows up as an operand or a flag that changes when it should not.

// File: rtl/slice_alu8.sv
module slice_alu8 #(
  parameter int W  = 8,
  parameter int SW = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_in,
  input  logic         a_load_n,
  input  logic         b_load_n,
  input  logic         flag_we_n,
  input  logic         out_en_n,
  input  logic [3:0]   sel,
  input  logic         mode,
  input  logic         cin_n,
  output logic [W-1:0] result,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  output logic         cf,
  output logic         zf
);
  localparam int NS = W / SW;

  logic [W-1:0] ra, rb, xv, yv;
  logic [NS:0]  c;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ra <= '0;
      rb <= '0;
    end else begin
      if (!a_load_n) ra <= bus_in;
      if (!b_load_n) rb <= bus_in;
    end

  assign xv   = ra | ({W{sel[0]}} & rb) | ({W{sel[1]}} & ~rb);
  assign yv   = ({W{sel[3]}} & ra & rb) | ({W{sel[2]}} & ra & ~rb);
  assign c[0] = ~mode & ~cin_n;

  for (genvar g = 0; g < NS; g++) begin : g_slice
    logic [SW:0] s;
    assign s = {1'b0, xv[g*SW +: SW]} + {1'b0, yv[g*SW +: SW]} + {{SW{1'b0}}, c[g]};
    assign c[g+1] = s[SW] & ~mode;
    assign result[g*SW +: SW] = mode ? ~(xv[g*SW +: SW] ^ yv[g*SW +: SW]) : s[SW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cf <= 1'b0;
      zf <= 1'b0;
    end else if (!flag_we_n) begin
      cf <= c[NS];
      zf <= ~|result;
    end

  assign bus_oe  = ~out_en_n;
  assign bus_out = out_en_n ? '0 : result;
endmodule

// File: rtl/slice_alu8_chk.sv
module slice_alu8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] bus_in,
  input logic         a_load_n,
  input logic         flag_we_n,
  input logic         mode,
  input logic [3:0]   sel,
  input logic [W-1:0] ra,
  input logic [W-1:0] result,
  input logic [W-1:0] bus_out,
  input logic         bus_oe,
  input logic         cf,
  input logic         zf
);
  AST_A_LOAD: assert property (@(posedge clk) disable iff (!rst_n) !a_load_n |=> ra == $past(bus_in)); // R1
  AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n) a_load_n |=> $stable(ra)); // R1
  AST_RST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> !cf && !zf); // R2
  AST_LOGIC_ZERO: assert property (@(posedge clk) disable iff (!rst_n) mode && sel == 4'b0011 |-> result == '0); // R4
  AST_LOGIC_NO_CF: assert property (@(posedge clk) disable iff (!rst_n) !flag_we_n && mode |=> !cf); // R6
  AST_ZF_LOAD: assert property (@(posedge clk) disable iff (!rst_n) !flag_we_n |=> zf == ($past(result) == '0)); // R7
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) flag_we_n |=> $stable({cf, zf})); // R8
  AST_BUS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) bus_oe |-> bus_out == result); // R9
endmodule

bind slice_alu8 slice_alu8_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .a_load_n(a_load_n),
  .flag_we_n(flag_we_n), .mode(mode), .sel(sel), .ra(ra), .result(result),
  .bus_out(bus_out), .bus_oe(bus_oe), .cf(cf), .zf(zf)
);

// File: tb/tb_slice_alu8.sv
module tb_slice_alu8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_in = '0;
  logic a_load_n = 1'b1, b_load_n = 1'b1, flag_we_n = 1'b1, out_en_n = 1'b1;
  logic [3:0] sel = '0;
  logic mode = 1'b0, cin_n = 1'b1;
  logic [7:0] result, bus_out;
  logic bus_oe, cf, zf;
  int checks = 0, errors = 0;
  logic [7:0] ma, mb;
  logic mcf, mzf;

  always #4 clk = ~clk;

  slice_alu8 dut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .a_load_n(a_load_n), .b_load_n(b_load_n),
    .flag_we_n(flag_we_n), .out_en_n(out_en_n), .sel(sel), .mode(mode), .cin_n(cin_n),
    .result(result), .bus_out(bus_out), .bus_oe(bus_oe), .cf(cf), .zf(zf)
  );

  function automatic logic [8:0] ref_alu(input logic [7:0] a, input logic [7:0] b,
                                         input logic [3:0] s, input logic m, input logic cn);
    int unsigned v, k;
    logic [7:0] nb, f;
    nb = ~b;
    k  = cn ? 0 : 1;
    if (m) begin
      case (s)
        4'd0:  f = ~a;
        4'd1:  f = ~(a | b);
        4'd2:  f = ~a & b;
        4'd3:  f = 8'h00;
        4'd4:  f = ~(a & b);
        4'd5:  f = nb;
        4'd6:  f = a ^ b;
        4'd7:  f = a & nb;
        4'd8:  f = ~a | b;
        4'd9:  f = ~(a ^ b);
        4'd10: f = b;
        4'd11: f = a & b;
        4'd12: f = 8'hFF;
        4'd13: f = a | nb;
        4'd14: f = a | b;
        default: f = a;
      endcase
      return {1'b0, f};
    end
    case (s)
      4'd0:  v = a + k;
      4'd1:  v = (a | b) + k;
      4'd2:  v = (a | nb) + k;
      4'd3:  v = 255 + k;
      4'd4:  v = a + (a & nb) + k;
      4'd5:  v = (a | b) + (a & nb) + k;
      4'd6:  v = a + nb + k;
      4'd7:  v = (a & nb) + 255 + k;
      4'd8:  v = a + (a & b) + k;
      4'd9:  v = a + b + k;
      4'd10: v = (a | nb) + (a & b) + k;
      4'd11: v = (a & b) + 255 + k;
      4'd12: v = a + a + k;
      4'd13: v = (a | b) + a + k;
      4'd14: v = (a | nb) + a + k;
      default: v = a + 255 + k;
    endcase
    return v[8:0];
  endfunction

  task automatic ck(input logic ok, input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    logic [8:0] r;
    if (!rst_n) begin
      ma <= '0; mb <= '0; mcf <= 1'b0; mzf <= 1'b0;
    end else begin
      r = ref_alu(ma, mb, sel, mode, cin_n);
      if (!a_load_n) ma <= bus_in;
      if (!b_load_n) mb <= bus_in;
      if (!flag_we_n) begin
        mcf <= r[8];
        mzf <= (r[7:0] == 8'h00);
      end
    end
  end

  always @(negedge clk) begin
    logic [8:0] e;
    e = ref_alu(ma, mb, sel, mode, cin_n);
    ck(result == e[7:0], mode ? "R4 result" : "R3 result", {1'b0, result}, {1'b0, e[7:0]});
    ck(cf == mcf, "R6 cf", {8'd0, cf}, {8'd0, mcf});
    ck(zf == mzf, "R7 zf", {8'd0, zf}, {8'd0, mzf});
    ck(bus_oe == !out_en_n, "R9 bus_oe", {8'd0, bus_oe}, {8'd0, !out_en_n});
    ck(bus_out == (out_en_n ? 8'h00 : e[7:0]), "R9 bus_out", {1'b0, bus_out},
       {1'b0, out_en_n ? 8'h00 : e[7:0]});
  end

  task automatic set(input logic [7:0] d, input logic al, input logic bl, input logic fw,
                     input logic oe, input logic [3:0] s, input logic m, input logic cn);
    @(negedge clk);
    #1;
    bus_in = d; a_load_n = al; b_load_n = bl; flag_we_n = fw;
    out_en_n = oe; sel = s; mode = m; cin_n = cn;
  endtask

  task automatic look(input logic [3:0] s, input logic m);
    set(8'hA5, 1'b1, 1'b1, 1'b1, 1'b0, s, m, 1'b1);
    @(negedge clk);
    #2;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    ck(cf == 1'b0 && zf == 1'b0, "R2 flags in reset", {7'd0, cf, zf}, 9'd0);
    look(4'b1111, 1'b1);
    ck(result == 8'h00, "R2 A cleared", {1'b0, result}, 9'h000);
    @(negedge clk);
    #1 rst_n = 1'b1;

    set(8'h3C, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0000, 1'b0, 1'b1);
    set(8'h5A, 1'b1, 1'b0, 1'b1, 1'b1, 4'b0000, 1'b0, 1'b1);
    look(4'b1111, 1'b1);
    ck(result == 8'h3C, "R1 A loaded", {1'b0, result}, 9'h03C);
    look(4'b1010, 1'b1);
    ck(result == 8'h5A, "R1 B loaded", {1'b0, result}, 9'h05A);
    set(8'hC3, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0000, 1'b0, 1'b1);
    look(4'b1111, 1'b1);
    ck(result == 8'h3C, "R1 A held", {1'b0, result}, 9'h03C);

    set(8'h0F, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0000, 1'b0, 1'b1);
    set(8'h01, 1'b1, 1'b0, 1'b1, 1'b1, 4'b0000, 1'b0, 1'b1);
    look(4'b1001, 1'b0);
    ck(result == 8'h10, "R5 nibble carry", {1'b0, result}, 9'h010);

    set(8'h80, 1'b0, 1'b0, 1'b1, 1'b1, 4'b1001, 1'b0, 1'b1);
    set(8'h80, 1'b1, 1'b1, 1'b0, 1'b1, 4'b1001, 1'b0, 1'b1);
    set(8'h11, 1'b0, 1'b1, 1'b1, 1'b0, 4'b1001, 1'b0, 1'b1);
    @(negedge clk);
    #2;
    ck(cf == 1'b1, "R6 carry out set", {8'd0, cf}, 9'd1);
    ck(zf == 1'b1, "R7 zero result", {8'd0, zf}, 9'd1);
    ck(result == 8'h91, "R8 operands changed", {1'b0, result}, 9'h091);
    ck(cf == 1'b1 && zf == 1'b1, "R8 flags held", {7'd0, cf, zf}, 9'd3);

    for (int s = 0; s < 16; s++)
      for (int m = 0; m < 2; m++)
        for (int cn = 0; cn < 2; cn++)
          for (int p = 0; p < 3; p++) begin
            logic [7:0] a, b;
            a = 8'($urandom);
            b = 8'($urandom);
            if (p == 0) begin a = 8'hFF; b = 8'h01; end
            set(a, 1'b0, 1'b1, 1'b1, 1'b1, 4'(s), 1'(m), 1'(cn));
            set(b, 1'b1, 1'b0, 1'b1, 1'b1, 4'(s), 1'(m), 1'(cn));
            set(8'h00, 1'b1, 1'b1, 1'b0, 1'(p & 1), 4'(s), 1'(m), 1'(cn));
            set(8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 4'(s), 1'(m), 1'(cn));
          end

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule